// File: doc/BRIEF.md
# Synchronous Burst Address Controller

This block produces the word address presented to a synchronous burst memory array. On a rising clock edge it either takes a fresh external address or steps a small counter through the low address bits. A fresh address comes from one of two active-low strobes. The processor strobe always starts a read-only burst. The controller strobe starts a burst that may read or write. Chip enable qualifies both strobes, but in different ways.

A static mode pin selects the burst order. In linear order the count is added to the loaded low bits, wrapping within the group. In interleaved order the count is XORed with the loaded low bits. An active-low advance input steps the burst by one word, and leaving it high holds the current word, which acts as a wait state. The block is built around a three-state machine:

- `ST_DESEL`: deselected or powered down.
- `ST_RD_BURST`: a burst started by the processor strobe.
- `ST_RW_BURST`: a burst started by the controller strobe.

Every edge is evaluated in a fixed priority, and each transition carries a name:

1. **T_PLOAD**: the processor strobe with chip enable low enters `ST_RD_BURST` from any state and loads the address.
2. **T_CLOAD**: the controller strobe with chip enable low enters `ST_RW_BURST` from any state and loads the address.
3. **T_PDOWN**: the controller strobe with chip enable high enters `ST_DESEL` from any state.
4. **T_STEP / T_WAIT**: a burst state with no load stays in place and either advances or holds.
5. **T_IDLE**: `ST_DESEL` with nothing loaded stays in place.

Top module: `burst_addr_ctrl`

## Requirements
- R1: After reset, `addr_o` is all zeros and `cyc_o` is 2'b00. In `cyc_o`, 2'b00 means deselected, 2'b01 means read-only and 2'b10 means read-or-write.
- R2: When `proc_strb_n` is low and `ce_n` is low at an edge, `addr_o` equals `addr_i` from that edge and `cyc_o` becomes 2'b01.
- R3: When `proc_strb_n` is low and `ce_n` is high (with `ctrl_strb_n` high and `adv_n` high), `addr_o` and `cyc_o` remain unchanged.
- R4: When `ctrl_strb_n` is low, `ce_n` is low and `proc_strb_n` is high, `addr_i` is loaded and `cyc_o` becomes 2'b10.
- R5: When `ctrl_strb_n` is low and `ce_n` is high, `cyc_o` becomes 2'b00. While deselected, `adv_n` low leaves `addr_o` unchanged.
- R6: When both strobes are low with `ce_n` low, the processor strobe wins: `cyc_o` becomes 2'b01 and `addr_i` is loaded.
- R7: During a burst, `adv_n` low steps the burst offset by one at the edge. `adv_n` high leaves `addr_o` unchanged.
- R8: With `mode_i` low, the low two address bits equal the loaded low bits plus the offset, modulo 4.
- R9: With `mode_i` high, the low two address bits equal the loaded low bits XOR the offset.
- R10: Address bits above the low two never change without a load. After four advances, the address returns to the loaded address.
- R11: A strobe that loads during a burst restarts the offset at zero with the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Current word address |
| cyc_o | output | 2 | Cycle type: 00 deselected, 01 read-only, 10 read-or-write |

## Verification
Every result appears one edge after the stimulus that causes it. The strobe decision, the load or step, and the state change all register at the same edge. The order mapping that follows is combinational, so `addr_o` and `cyc_o` carry the effect of an edge until the next one. The bench changes inputs at the falling edge and checks the outputs at the following falling edge. Every check therefore lands exactly one rising edge after its stimulus, and no stimulus is given twice.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [1:0] {
        ST_DESEL    = 2'b00,
        ST_RD_BURST = 2'b01,
        ST_RW_BURST = 2'b10
    } bac_state_e;

    typedef enum logic [1:0] {
        CYC_NONE = 2'b00,
        CYC_READ = 2'b01,
        CYC_RDWR = 2'b10
    } bac_cyc_e;

endpackage

// File: rtl/bac_fsm.sv
module bac_fsm
    import bac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_strb_n,
    input  logic       ctrl_strb_n,
    input  logic       adv_n,
    input  logic       ce_n,
    output logic       load_o,
    output logic       step_o,
    output bac_cyc_e   cyc_o
);

    bac_state_e state_q, state_d;
    logic       proc_go, ctrl_go, pdown;

    // Strobe decode; the processor strobe takes priority while enabled.
    assign proc_go = !proc_strb_n && !ce_n;
    assign ctrl_go = !proc_go && !ctrl_strb_n && !ce_n;
    assign pdown   = !proc_go && !ctrl_strb_n && ce_n;

    // Next state and per-edge actions
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        step_o  = 1'b0;
        if (proc_go) begin                    // T_PLOAD
            state_d = ST_RD_BURST;
            load_o  = 1'b1;
        end else if (ctrl_go) begin           // T_CLOAD
            state_d = ST_RW_BURST;
            load_o  = 1'b1;
        end else if (pdown) begin             // T_PDOWN
            state_d = ST_DESEL;
        end else begin
            unique case (state_q)
                ST_DESEL:    state_d = ST_DESEL;          // T_IDLE
                ST_RD_BURST,
                ST_RW_BURST: step_o  = !adv_n;            // T_STEP / T_WAIT
                default:     state_d = ST_DESEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_DESEL:    cyc_o = CYC_NONE;
            ST_RD_BURST: cyc_o = CYC_READ;
            ST_RW_BURST: cyc_o = CYC_RDWR;
            default:     cyc_o = CYC_NONE;
        endcase
    end

    a_r1_cyc_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cyc_o));

    a_r2_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !ce_n) |=> (cyc_o == CYC_READ));

    a_r4_ctrl_rdwr: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && !ctrl_strb_n && !ce_n) |=> (cyc_o == CYC_RDWR));

    a_r5_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strb_n && ce_n) |=> (cyc_o == CYC_NONE));

    a_r6_proc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !ctrl_strb_n && !ce_n) |=> (cyc_o == CYC_READ));

endmodule

// File: rtl/bac_cnt.sv
module bac_cnt #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o <= '0;
            cnt_o  <= '0;
        end else if (load_i) begin
            base_o <= addr_i;
            cnt_o  <= '0;
        end else if (step_i) begin
            cnt_o  <= cnt_o + ONE;
        end
    end

    a_r3_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base_o));

    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(cnt_o));

    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == '0));

endmodule

// File: rtl/bac_order.sv
module bac_order #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             mode_i,
    output logic [CNT_W-1:0] low_o
);

    logic [CNT_W-1:0] lin_w, ilv_w;

    assign lin_w = start_i + cnt_i;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_w[b] = start_i[b] ^ cnt_i[b];
    end

    assign low_o = mode_i ? ilv_w : lin_w;

endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import bac_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        cyc_o
);

    logic              load_w, step_w;
    bac_cyc_e          cyc_w;
    logic [ADDR_W-1:0] base_w;
    logic [CNT_W-1:0]  cnt_w, low_w;

    bac_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .ce_n        (ce_n),
        .load_o      (load_w),
        .step_o      (step_w),
        .cyc_o       (cyc_w)
    );

    bac_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .step_i (step_w),
        .addr_i (addr_i),
        .base_o (base_w),
        .cnt_o  (cnt_w)
    );

    bac_order #(.CNT_W(CNT_W)) u_order (
        .start_i (base_w[CNT_W-1:0]),
        .cnt_i   (cnt_w),
        .mode_i  (mode_i),
        .low_o   (low_w)
    );

    assign addr_o = {base_w[ADDR_W-1:CNT_W], low_w};
    assign cyc_o  = cyc_w;

    a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> $stable(addr_o[ADDR_W-1:CNT_W]));

    a_r5_desel_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == 2'b00 && !load_w) |=> $stable(addr_o));

endmodule

// File: tb/burst_addr_ctrl_tb_top.sv
module burst_addr_ctrl_tb_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1, mode_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic [1:0]        cyc_o;

    int n_run = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .proc_strb_n(proc_strb_n),
        .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .ce_n(ce_n), .mode_i(mode_i),
        .addr_o(addr_o), .cyc_o(cyc_o)
    );

    function automatic logic [ADDR_W-1:0] mk(input logic [ADDR_W-1:0] b, input logic [1:0] lo);
        return {b[ADDR_W-1:2], lo};
    endfunction

    // Drive one edge's inputs at a falling edge, return at the next falling edge
    task automatic edge_in(input logic pn, input logic cn, input logic ce, input logic av,
                           input logic [ADDR_W-1:0] a);
        proc_strb_n = pn; ctrl_strb_n = cn; ce_n = ce; adv_n = av; addr_i = a;
        @(posedge clk);
        @(negedge clk);
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic chk(input string tag, input logic [ADDR_W-1:0] ea, input logic [1:0] ec);
        n_run++;
        if (addr_o !== ea || cyc_o !== ec) begin
            n_fail++;
            $display("FAIL %s: addr=%h cyc=%b expected addr=%h cyc=%b", tag, addr_o, cyc_o, ea, ec);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset state", '0, 2'b00);
    endtask

    task automatic t_linear;
        logic [ADDR_W-1:0] a = 19'h12346;
        mode_i = 1'b0;
        edge_in(0, 1, 0, 1, a);
        chk("R2 proc load", a, 2'b01);
        edge_in(1, 1, 0, 0, '0);
        chk("R7 R8 linear step 1", mk(a, 2'b11), 2'b01);
        edge_in(1, 1, 0, 1, '0);
        chk("R7 wait holds", mk(a, 2'b11), 2'b01);
        edge_in(1, 1, 0, 0, '0);
        chk("R8 linear step 2 wraps low bits", mk(a, 2'b00), 2'b01);
        edge_in(1, 1, 0, 0, '0);
        chk("R8 R10 linear step 3 upper fixed", mk(a, 2'b01), 2'b01);
        edge_in(1, 1, 0, 0, '0);
        chk("R10 linear wrap to start", a, 2'b01);
    endtask

    task automatic t_interleave;
        logic [ADDR_W-1:0] a = 19'h5A5A5;
        mode_i = 1'b1;
        edge_in(1, 0, 0, 1, a);
        chk("R4 ctrl load", a, 2'b10);
        edge_in(1, 1, 0, 0, '0);
        chk("R9 interleave step 1", mk(a, 2'b00), 2'b10);
        edge_in(1, 1, 0, 0, '0);
        chk("R9 interleave step 2", mk(a, 2'b11), 2'b10);
        edge_in(1, 1, 0, 0, '0);
        chk("R9 interleave step 3", mk(a, 2'b10), 2'b10);
        edge_in(1, 1, 0, 0, '0);
        chk("R10 interleave wrap to start", a, 2'b10);
    endtask

    task automatic t_ignore;
        edge_in(0, 1, 1, 1, 19'h7FFFF);
        chk("R3 proc ignored with ce high", 19'h5A5A5, 2'b10);
    endtask

    task automatic t_abort;
        logic [ADDR_W-1:0] a = 19'h00F0E;
        mode_i = 1'b0;
        edge_in(1, 1, 0, 0, '0);
        chk("R7 step before abort", 19'h5A5A6, 2'b10);
        edge_in(1, 0, 0, 1, a);
        chk("R11 abort restarts at new address", a, 2'b10);
    endtask

    task automatic t_priority;
        logic [ADDR_W-1:0] a = 19'h31233;
        edge_in(0, 0, 0, 1, a);
        chk("R6 proc wins over ctrl", a, 2'b01);
    endtask

    task automatic t_pdown;
        edge_in(1, 0, 1, 1, 19'h11111);
        chk("R5 powerdown", 19'h31233, 2'b00);
        edge_in(1, 1, 1, 0, '0);
        chk("R5 advance ignored while deselected", 19'h31233, 2'b00);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_interleave();
        t_ignore();
        t_abort();
        t_priority();
        t_pdown();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule